// File: doc/BRIEF.md
# Line-Doubled Framebuffer Video Scanout

This block generates the horizontal and vertical synchronisation pulses of a VGA display and streams pixel bytes from a framebuffer memory to an 8-bit pixel output. A horizontal counter sets the line period and places a negative-going hsync pulse after the pixel data. A line counter drives a four-phase vertical sequencer: back porch, visible, front porch, then vsync. The counter is cleared when the vsync phase ends, and the sequence starts again at the back porch.

During the visible phase the block reads one framebuffer row through a synchronous read port with one clock of latency. It shows each row on two consecutive scan lines, so a 160-pixel-wide image is also halved vertically. The row address is reloaded with the framebuffer base when the visible phase begins. It advances by one row length only before a line whose count is even, and it wraps back to the base at the end of the screen area. Every clock that carries no pixel drives a blanking byte. A one-clock frame-start strobe marks each return to the back porch. All timing thresholds, the base address and the screen size are parameters.

Top module: `vga_scanout`

Horizontal count 0 is the first clock after reset is released; a line is H_TOTAL clocks long. The defaults are used throughout: H_TOTAL=200, PIX_PER_LINE=160, HSYNC_START=168, HSYNC_END=184, VISIBLE_START=2, VFP_START=12, VSYNC_START=14, VSYNC_END=16, BASE_ADDR=100, SCREEN_SIZE=640, BLANK_BYTE=0.

## Requirements
- R1: hsyncN is low for exactly HSYNC_END-HSYNC_START clocks of each line, going low on the clock after the horizontal count equals HSYNC_START.
- R2: The phases run back porch, visible, front porch, vsync. A frame is VSYNC_END lines long, and lines VISIBLE_START to VFP_START-1 of each frame are visible. memRdEn is high only in visible lines, for one clock after each horizontal count from 0 to PIX_PER_LINE-1.
- R3: A visible line drives exactly PIX_PER_LINE consecutive pixel bytes. The byte read for horizontal count h appears on pixOut three clocks after the clock with count h.
- R4: Each framebuffer row is shown on two consecutive scan lines. The first visible line of every frame reads from BASE_ADDR, and pixel h of a row at address A is read from address A+h.
- R5: When the row address advanced by PIX_PER_LINE would reach BASE_ADDR+SCREEN_SIZE, it wraps to BASE_ADDR. With the defaults, the fifth displayed row repeats the first.
- R6: pixOut equals BLANK_BYTE on every clock that carries no pixel, including the clocks after the last pixel of a line and all of every non-visible line.
- R7: vsyncN changes only at line starts. It is low for VSYNC_END-VSYNC_START lines, starting one line after the vsync phase is entered and ending one line after it is left.
- R8: frameStart is a one-clock pulse on the first clock of frame line 0, on every entry to the back porch after the first frame.
- R9: While rstN is low, hsyncN and vsyncN are high, frameStart and memRdEn are low, and pixOut equals BLANK_BYTE. Reset taken in the middle of a visible line restarts a clean frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| memRdEn | output | 1 | Framebuffer read strobe |
| memRdAddr | output | ADDR_W | Framebuffer read address |
| memRdData | input | 8 | Read data, valid one clock after memRdEn |
| pixOut | output | 8 | Pixel byte or blanking byte |
| hsyncN | output | 1 | Horizontal sync, active low |
| vsyncN | output | 1 | Vertical sync, active low |
| frameStart | output | 1 | One-clock strobe on entry to the back porch |

## Verification
The assertions assume that the threshold parameters increase strictly from VISIBLE_START to VSYNC_END, that VISIBLE_START is even and non-zero, and that the hsync window lies after the pixel pipeline drains and before the line ends. They also assume that the memory returns data exactly one clock after a read strobe. The bench keeps within these limits: it uses the default thresholds and models the framebuffer as a register that loads a pattern of the address on each strobe. The pattern never equals the blanking byte, so a pixel can never be mistaken for blanking.

// File: rtl/vga_scan_pkg.sv
package vga_scan_pkg;

  typedef enum logic [1:0] {
    PH_BACK  = 2'd0,
    PH_VIS   = 2'd1,
    PH_FRONT = 2'd2,
    PH_SYNC  = 2'd3
  } vPhase_e;

  // Strobes from the timing control to the address/pixel datapath
  typedef struct packed {
    logic lineEnd;
    logic rowReload;
    logic rowAdvance;
    logic fetch;
  } scanStrobes_t;

  function automatic vPhase_e succPhase(vPhase_e p);
    case (p)
      PH_BACK:  return PH_VIS;
      PH_VIS:   return PH_FRONT;
      PH_FRONT: return PH_SYNC;
      default:  return PH_BACK;
    endcase
  endfunction

endpackage

// File: rtl/vga_scan_ctrl.sv
module vga_scan_ctrl
  import vga_scan_pkg::*;
#(
  parameter int H_TOTAL       = 200,
  parameter int PIX_PER_LINE  = 160,
  parameter int HSYNC_START   = 168,
  parameter int HSYNC_END     = 184,
  parameter int VISIBLE_START = 2,
  parameter int VFP_START     = 12,
  parameter int VSYNC_START   = 14,
  parameter int VSYNC_END     = 16,
  parameter int HW            = $clog2(H_TOTAL)
) (
  input  logic              clk,
  input  logic              rstN,
  output scanStrobes_t      strobes,
  output logic [HW-1:0]     colIdx,
  output logic              hsyncN,
  output logic              vsyncN,
  output logic              frameStart
);

  localparam int VW = $clog2(VSYNC_END + 1);
  localparam logic [HW-1:0] H_LAST  = HW'(H_TOTAL - 1);
  localparam logic [HW-1:0] HS_C    = HW'(HSYNC_START);
  localparam logic [HW-1:0] HE_C    = HW'(HSYNC_END);
  localparam logic [HW-1:0] PIX_C   = HW'(PIX_PER_LINE);
  localparam logic [VW-1:0] VIS_C   = VW'(VISIBLE_START);
  localparam logic [VW-1:0] VFP_C   = VW'(VFP_START);
  localparam logic [VW-1:0] VSS_C   = VW'(VSYNC_START);
  localparam logic [VW-1:0] VSE_C   = VW'(VSYNC_END);

  logic [HW-1:0] hCnt;
  logic [VW-1:0] lineCnt, nxtLine, lineNext;
  vPhase_e       phase, phaseNext;
  logic          lineEnd, reload, advance, wrapFrame;

  assign lineEnd = (hCnt == H_LAST);
  assign nxtLine = lineCnt + VW'(1);

  // Phase decision, evaluated against the count of the line about to start
  always_comb begin
    phaseNext = phase;
    lineNext  = nxtLine;
    reload    = 1'b0;
    advance   = 1'b0;
    wrapFrame = 1'b0;
    case (phase)
      PH_BACK: if (nxtLine >= VIS_C) begin
        phaseNext = PH_VIS;
        reload    = 1'b1;
      end
      PH_VIS: begin
        if (nxtLine >= VFP_C) phaseNext = PH_FRONT;
        else if (!nxtLine[0]) advance = 1'b1;
      end
      PH_FRONT: if (nxtLine >= VSS_C) phaseNext = PH_SYNC;
      default: if (nxtLine >= VSE_C) begin
        phaseNext = PH_BACK;
        lineNext  = '0;
        wrapFrame = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCnt       <= '0;
      lineCnt    <= '0;
      phase      <= PH_BACK;
      hsyncN     <= 1'b1;
      vsyncN     <= 1'b1;
      frameStart <= 1'b0;
    end else begin
      hsyncN     <= !((hCnt >= HS_C) && (hCnt < HE_C));
      frameStart <= 1'b0;
      if (lineEnd) begin
        hCnt       <= '0;
        lineCnt    <= lineNext;
        phase      <= phaseNext;
        vsyncN     <= (phase != PH_SYNC);
        frameStart <= wrapFrame;
      end else begin
        hCnt <= hCnt + HW'(1);
      end
    end
  end

  assign strobes.lineEnd    = lineEnd;
  assign strobes.rowReload  = lineEnd & reload;
  assign strobes.rowAdvance = lineEnd & advance;
  assign strobes.fetch      = (phase == PH_VIS) && (hCnt < PIX_C);
  assign colIdx             = hCnt;

  assert_hsync_start_R1: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hsyncN) |-> (hCnt == HS_C + HW'(1)));

  assert_phase_order_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(phase) |-> (phase == succPhase($past(phase))));

  assert_vsync_line_edge_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(vsyncN) |-> (hCnt == '0));

  assert_frame_start_pos_R8: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> (hCnt == '0 && phase == PH_BACK && lineCnt == '0));

endmodule

// File: rtl/vga_scan_dp.sv
module vga_scan_dp
  import vga_scan_pkg::*;
#(
  parameter int          PIX_PER_LINE = 160,
  parameter int          ADDR_W       = 16,
  parameter int          BASE_ADDR    = 100,
  parameter int          SCREEN_SIZE  = 640,
  parameter logic [7:0]  BLANK_BYTE   = 8'h00,
  parameter int          HW           = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  scanStrobes_t      strobes,
  input  logic [HW-1:0]     colIdx,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic [7:0]        memRdData,
  output logic [7:0]        pixOut
);

  localparam logic [ADDR_W-1:0] BASE_C  = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W:0]   LIMIT_C = (ADDR_W+1)'(BASE_ADDR + SCREEN_SIZE);
  localparam logic [ADDR_W:0]   STEP_C  = (ADDR_W+1)'(PIX_PER_LINE);

  logic [ADDR_W-1:0] rowAddr;
  logic [ADDR_W:0]   rowSum;
  logic              rdValid;

  assign rowSum = {1'b0, rowAddr} + STEP_C;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowAddr   <= BASE_C;
      memRdEn   <= 1'b0;
      memRdAddr <= '0;
      rdValid   <= 1'b0;
      pixOut    <= BLANK_BYTE;
    end else begin
      if (strobes.rowReload)
        rowAddr <= BASE_C;
      else if (strobes.rowAdvance)
        rowAddr <= (rowSum >= LIMIT_C) ? BASE_C : rowSum[ADDR_W-1:0];
      memRdEn   <= strobes.fetch;
      memRdAddr <= rowAddr + ADDR_W'(colIdx);
      rdValid   <= memRdEn;
      pixOut    <= rdValid ? memRdData : BLANK_BYTE;
    end
  end

  assert_row_in_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    ({1'b0, rowAddr} < LIMIT_C) && (rowAddr >= BASE_C));

  assert_fetch_from_row_R4: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> ({1'b0, memRdAddr} < LIMIT_C + STEP_C));

endmodule

// File: rtl/vga_scanout.sv
module vga_scanout
  import vga_scan_pkg::*;
#(
  parameter int         H_TOTAL       = 200,
  parameter int         PIX_PER_LINE  = 160,
  parameter int         HSYNC_START   = 168,
  parameter int         HSYNC_END     = 184,
  parameter int         VISIBLE_START = 2,
  parameter int         VFP_START     = 12,
  parameter int         VSYNC_START   = 14,
  parameter int         VSYNC_END     = 16,
  parameter int         ADDR_W        = 16,
  parameter int         BASE_ADDR     = 100,
  parameter int         SCREEN_SIZE   = 640,
  parameter logic [7:0] BLANK_BYTE    = 8'h00
) (
  input  logic              clk,
  input  logic              rstN,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic [7:0]        memRdData,
  output logic [7:0]        pixOut,
  output logic              hsyncN,
  output logic              vsyncN,
  output logic              frameStart
);

  localparam int HW = $clog2(H_TOTAL);

  scanStrobes_t  strobes;
  logic [HW-1:0] colIdx;

  vga_scan_ctrl #(
    .H_TOTAL(H_TOTAL), .PIX_PER_LINE(PIX_PER_LINE),
    .HSYNC_START(HSYNC_START), .HSYNC_END(HSYNC_END),
    .VISIBLE_START(VISIBLE_START), .VFP_START(VFP_START),
    .VSYNC_START(VSYNC_START), .VSYNC_END(VSYNC_END), .HW(HW)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .strobes(strobes), .colIdx(colIdx),
    .hsyncN(hsyncN), .vsyncN(vsyncN), .frameStart(frameStart)
  );

  vga_scan_dp #(
    .PIX_PER_LINE(PIX_PER_LINE), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR),
    .SCREEN_SIZE(SCREEN_SIZE), .BLANK_BYTE(BLANK_BYTE), .HW(HW)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .colIdx(colIdx),
    .memRdEn(memRdEn), .memRdAddr(memRdAddr), .memRdData(memRdData),
    .pixOut(pixOut)
  );

endmodule

// File: tb/vga_scanout_test.sv
`timescale 1ns/1ps
module vga_scanout_test;

  localparam int H    = 200;
  localparam int PIX  = 160;
  localparam int HS   = 168;
  localparam int HE   = 184;
  localparam int FRM  = 16;
  localparam int BASE = 100;

  // Per frame line: [3]=visible, [2:1]=row shown, [0]=vsync low on this line
  localparam logic [3:0] LINE_TAB [16] = '{
    4'b0001, 4'b0000, 4'b1000, 4'b1000, 4'b1010, 4'b1010, 4'b1100, 4'b1100,
    4'b1110, 4'b1110, 4'b1000, 4'b1000, 4'b0000, 4'b0000, 4'b0000, 4'b0001
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        memRdEn, hsyncN, vsyncN, frameStart;
  logic [15:0] memRdAddr;
  logic [7:0]  memRdData = 8'h00;
  logic [7:0]  pixOut;
  int          checks = 0;
  int          fails = 0;
  int          frames = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  function automatic logic [7:0] pat(int a);
    return 8'((a % 251) + 1);
  endfunction

  always_ff @(posedge clk) if (memRdEn) memRdData <= pat(int'(memRdAddr));

  vga_scanout uut (
    .clk(clk), .rstN(rstN), .memRdEn(memRdEn), .memRdAddr(memRdAddr),
    .memRdData(memRdData), .pixOut(pixOut), .hsyncN(hsyncN),
    .vsyncN(vsyncN), .frameStart(frameStart)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Walk k samples after reset release, comparing all outputs with the table model
  task automatic runModel(int n);
    for (int k = 0; k < n; k++) begin
      int lk = k / H;
      int p = k - 1;
      bit hsLow = (k >= 1) && ((p % H) >= HS) && ((p % H) < HE);
      bit vsLow = (lk >= 1) && LINE_TAB[lk % FRM][0];
      bit fsExp = (k % H == 0) && (lk >= 1) && (lk % FRM == 0);
      bit rdExp = (k >= 1) && LINE_TAB[(p / H) % FRM][3] && ((p % H) < PIX);
      int pxExp = 0;
      string pxReq = "R6";
      if (k >= 3) begin
        int q = k - 3;
        int lf = (q / H) % FRM;
        logic [3:0] e = LINE_TAB[lf];
        if (!e[3]) pxReq = "R2";
        if (e[3] && (q % H) < PIX) begin
          pxExp = int'(pat(BASE + int'(e[2:1]) * PIX + (q % H)));
          pxReq = (lf >= 10) ? "R5" : "R4";
        end
      end
      chk("R1 hsync", int'(hsyncN), int'(!hsLow));
      chk("R7 vsync", int'(vsyncN), int'(!vsLow));
      chk("R8 frameStart", int'(frameStart), int'(fsExp));
      chk("R2 memRdEn", int'(memRdEn), int'(rdExp));
      chk(pxReq, int'(pixOut), pxExp);
      if (frameStart) frames++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset values
    chk("R9 hsync", int'(hsyncN), 1);
    chk("R9 vsync", int'(vsyncN), 1);
    chk("R9 frameStart", int'(frameStart), 0);
    chk("R9 memRdEn", int'(memRdEn), 0);
    chk("R9 pixOut", int'(pixOut), 0);
    rstN = 1'b1;
    // Two full frames plus the first clock of the third
    runModel(2 * FRM * H + 1);
    chk("R8 frame count", frames, 2);
    // Run into the middle of a visible line (frame line 3) then reset
    repeat (3 * H + 50) @(negedge clk);
    rstN = 1'b0;
    #1;
    chk("R9 mid-line pixOut", int'(pixOut), 0);
    chk("R9 mid-line memRdEn", int'(memRdEn), 0);
    chk("R9 mid-line hsync", int'(hsyncN), 1);
    @(negedge clk);
    rstN = 1'b1;
    runModel(2 * H + 3);
    // Now at line 2, count 3 after reset: first pixel of the first visible line
    chk("R4 first pixel after reset", int'(pixOut), int'(pat(BASE)));
    repeat (PIX - 1) @(negedge clk);
    chk("R3 last pixel", int'(pixOut), int'(pat(BASE + PIX - 1)));
    @(negedge clk);
    chk("R6 blank after last pixel", int'(pixOut), 0);
    // Next line repeats the same row
    repeat (H - PIX) @(negedge clk);
    chk("R4 doubled row first pixel", int'(pixOut), int'(pat(BASE)));
    repeat (H) @(negedge clk);
    chk("R4 second row first pixel", int'(pixOut), int'(pat(BASE + PIX)));
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule